// File: doc/BRIEF.md
# SPI Byte-Memory Command Engine

This block is the serial front end of a 512-byte memory. A host drives chip select, a serial clock and a data input. The engine takes in one command byte after chip select goes low, then executes it. A command may be followed by an address and a stream of data, and read data is shifted back out on a data output that has its own enable. Both idle clock levels are accepted: low (mode 0) and high (mode 3). In either case bits are captured when the serial clock rises and the output moves when it falls. All transfers are most significant bit first.

The serial pins are synchronised into a faster system clock, and the clock edges are found there. An active-low pause input freezes a transaction at any bit, and the transaction then continues where it stopped. The byte store sits outside the block. It is a synchronous RAM with one cycle of read latency, reached through an address, a write strobe, write data and read data. Write protection also lives outside. The engine sends it strobes that set or clear the write-enable latch and that carry a new status byte. In return, protection supplies the status byte to be read and two permit levels, one for memory writes at the current address and one for status writes.

Top module: `spi_mem_cmd`

## Requirements
- R1: Command byte 0x06 gives a one-cycle `latch_set` pulse, and command byte 0x04 gives a one-cycle `latch_clr` pulse.
- R2: Command bytes of the form 0000_A011 (read) and 0000_A010 (write) take bit 3 (A) as address bit 8. The next byte gives address bits 7..0.
- R3: During a memory write, every eighth captured data bit commits the assembled byte with one `mem_we` pulse at the current address. The address then steps by one, and 0x1FF is followed by 0x000. The byte count is unlimited.
- R4: During a memory read, bytes stream out from the start address with the same step-and-wrap rule for as long as chip select stays low, and the data input is ignored.
- R5: `so_oe` is high only while read data or status data is being shifted out. It is low during the command and address bytes, while chip select is high, and while the pause input is low.
- R6: While the pause input is low, serial clock edges are ignored. When the pause input returns high (with the serial clock low), the transfer resumes with no bit lost or repeated.
- R7: Only the first byte after chip select falls is decoded as a command. Bytes that follow a no-data command or an unknown command cause no strobe until chip select rises again.
- R8: Command byte 0x05 shifts out `stat_rdata`. Command byte 0x01 takes the next byte and presents it on `stat_wdata` with one `stat_wr` pulse, but only when `stat_wr_permit` is high.
- R9: When chip select rises after a memory write command (0000_A010) or a status write command (0x01), `latch_clr` pulses once.
- R10: When `mem_wr_permit` is low at the completion of a data byte, no `mem_we` is issued, but the address still steps.
- R11: During reset, `so_oe`, `mem_we`, `stat_wr`, `latch_set` and `latch_clr` are all low.
- R12: Mode 3 (serial clock idle high at chip select fall) transfers the same data as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; high means drive the pin |
| mem_addr | output | 9 | Byte address to the RAM |
| mem_we | output | 1 | One-cycle RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after `mem_addr` |
| latch_set | output | 1 | Pulse: set the write-enable latch |
| latch_clr | output | 1 | Pulse: clear the write-enable latch |
| stat_wr | output | 1 | Pulse: write `stat_wdata` into the status byte |
| stat_wdata | output | 8 | New status byte |
| stat_rdata | input | 8 | Current status byte for reading |
| mem_wr_permit | input | 1 | Memory write allowed at `mem_addr` |
| stat_wr_permit | input | 1 | Status write allowed |

## Verification
The assertions assume three things about the inputs. First, the serial clock stays at each level for at least three system cycles longer than the synchroniser delay, so that one edge is found per pin transition. Second, the pause input changes only while the serial clock is low. Third, `mem_rdata` follows `mem_addr` with a single cycle of latency. The bench drives every pin on the falling system clock edge, holds each serial clock phase for six system cycles, and moves the pause input only in the low phase, so all three conditions hold. Within those conditions it sweeps the whole address space in both clock modes and runs the wrap, permit, pause and discarded-byte cases.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADR,
    ST_WDAT,
    ST_RDAT,
    ST_RSTS,
    ST_WSTS,
    ST_SKIP
  } cmd_state_e;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] OP_MEM_RD_LO = 3'b011;
  localparam logic [2:0] OP_MEM_WR_LO = 3'b010;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_act,
  output logic cs_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic hold_s
);

  localparam logic [3:0] RST_VAL = 4'b1100;

  logic [3:0] pins;
  logic [3:0] stage_q [STAGES];
  logic [3:0] synced;
  logic       sck_q;
  logic       cs_q;
  logic       run;

  assign pins = {cs_n, hold_n, sck, si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      stage_q[0] <= pins;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      sck_q <= synced[1];
      cs_q  <= synced[3];
    end
  end

  assign synced   = stage_q[STAGES-1];
  assign cs_act   = ~synced[3];
  assign hold_s   = synced[2];
  assign si_s     = synced[0];
  assign run      = cs_act & hold_s;
  assign sck_rise = run & synced[1] & ~sck_q;
  assign sck_fall = run & ~synced[1] & sck_q;
  assign cs_end   = synced[3] & ~cs_q;

endmodule

// File: rtl/spi_addr_ctr.sv
module spi_addr_ctr #(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_hi,
  input  logic          hi_bit,
  input  logic          load_lo,
  input  logic [AW-2:0] lo_bits,
  input  logic          inc,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (load_hi) addr_d[AW-1] = hi_bit;
    if (load_lo) addr_d[AW-2:0] = lo_bits;
    if (inc) addr_d = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end

  // R3: top address rolls over to zero
  property p_wrap_r3;
    @(posedge clk) disable iff (!rst_n)
      (inc && !load_lo && !load_hi && addr == '1) |=> (addr == '0);
  endproperty
  a_wrap_r3: assert property (p_wrap_r3);

endmodule

// File: rtl/spi_out_shift.sv
module spi_out_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          shift,
  output logic          msb
);

  logic [DW-1:0] q, q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = din;
    else if (shift) q_d = {q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign msb = q[DW-1];

endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
  import spi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              latch_set,
  output logic              latch_clr,
  output logic              stat_wr,
  output logic [DATA_W-1:0] stat_wdata,
  input  logic [DATA_W-1:0] stat_rdata,
  input  logic              mem_wr_permit,
  input  logic              stat_wr_permit
);

  localparam int unsigned   CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic cs_act, cs_end, sck_rise, sck_fall, si_s, hold_s;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .cs_act(cs_act), .cs_end(cs_end), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_s(si_s), .hold_s(hold_s)
  );

  cmd_state_e        state, state_d;
  logic [CNT_W-1:0]  bitcnt, bitcnt_d;
  logic [DATA_W-2:0] shreg, shreg_d;
  logic              is_rd, is_rd_d;
  logic              wr_cls, wr_cls_d;
  logic              live, live_d;

  logic [DATA_W-1:0] rx_byte;
  logic              byte_done, op_rd, op_wr, rd_phase;
  logic              load_out, shift_out, addr_inc, load_hi, load_lo;
  logic              out_bit;

  assign rx_byte   = {shreg, si_s};
  assign byte_done = sck_rise && (bitcnt == LAST_BIT);
  assign op_rd     = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == OP_MEM_RD_LO);
  assign op_wr     = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == OP_MEM_WR_LO);
  assign rd_phase  = (state == ST_RDAT) || (state == ST_RSTS);

  always_comb begin
    state_d  = state;
    bitcnt_d = bitcnt;
    shreg_d  = shreg;
    is_rd_d  = is_rd;
    wr_cls_d = wr_cls;
    live_d   = live;
    if (!cs_act) begin
      state_d  = ST_OPC;
      bitcnt_d = '0;
      wr_cls_d = 1'b0;
      live_d   = 1'b0;
    end else begin
      if (sck_rise) begin
        shreg_d  = rx_byte[DATA_W-2:0];
        bitcnt_d = bitcnt + 1'b1;
      end
      if (byte_done) begin
        case (state)
          ST_OPC: begin
            if (op_rd) begin
              state_d = ST_ADR;
              is_rd_d = 1'b1;
            end else if (op_wr) begin
              state_d  = ST_ADR;
              is_rd_d  = 1'b0;
              wr_cls_d = 1'b1;
            end else if (rx_byte == OP_STAT_RD) begin
              state_d = ST_RSTS;
            end else if (rx_byte == OP_STAT_WR) begin
              state_d  = ST_WSTS;
              wr_cls_d = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
          ST_ADR:  state_d = is_rd ? ST_RDAT : ST_WDAT;
          ST_WSTS: state_d = ST_SKIP;
          default: state_d = state;
        endcase
      end
      if (load_out) live_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_OPC;
      bitcnt <= '0;
      shreg  <= '0;
      is_rd  <= 1'b0;
      wr_cls <= 1'b0;
      live   <= 1'b0;
    end else begin
      state  <= state_d;
      bitcnt <= bitcnt_d;
      shreg  <= shreg_d;
      is_rd  <= is_rd_d;
      wr_cls <= wr_cls_d;
      live   <= live_d;
    end
  end

  assign load_out  = cs_act && sck_fall && (bitcnt == '0) && rd_phase;
  assign shift_out = cs_act && sck_fall && (bitcnt != '0);
  assign addr_inc  = (byte_done && state == ST_WDAT) || (load_out && state == ST_RDAT);
  assign load_hi   = byte_done && (state == ST_OPC) && (op_rd || op_wr);
  assign load_lo   = byte_done && (state == ST_ADR);

  spi_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .hi_bit(rx_byte[3]),
    .load_lo(load_lo), .lo_bits(rx_byte[ADDR_W-2:0]), .inc(addr_inc),
    .addr(mem_addr)
  );

  spi_out_shift #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load_out),
    .din((state == ST_RDAT) ? mem_rdata : stat_rdata),
    .shift(shift_out), .msb(out_bit)
  );

  assign so         = out_bit;
  assign so_oe      = live && cs_act && hold_s;
  assign mem_we     = byte_done && (state == ST_WDAT) && mem_wr_permit;
  assign mem_wdata  = rx_byte;
  assign stat_wr    = byte_done && (state == ST_WSTS) && stat_wr_permit;
  assign stat_wdata = rx_byte;
  assign latch_set  = byte_done && (state == ST_OPC) && (rx_byte == OP_LATCH_SET);
  assign latch_clr  = (byte_done && (state == ST_OPC) && (rx_byte == OP_LATCH_CLR))
                    || (cs_end && wr_cls);

  // R5: output driven only in a read phase
  property p_oe_state_r5;
    @(posedge clk) disable iff (!rst_n)
      so_oe |-> (state == ST_RDAT || state == ST_RSTS);
  endproperty
  a_oe_state_r5: assert property (p_oe_state_r5);

  // R3: each committed byte advances the address by one
  property p_we_adv_r3;
    @(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
  endproperty
  a_we_adv_r3: assert property (p_we_adv_r3);

  // R7: at most one side-effect strobe per cycle
  property p_strobe_excl_r7;
    @(posedge clk) disable iff (!rst_n)
      $onehot0({latch_set, latch_clr, stat_wr, mem_we});
  endproperty
  a_strobe_excl_r7: assert property (p_strobe_excl_r7);

  // R6: bit position frozen while paused
  property p_hold_freeze_r6;
    @(posedge clk) disable iff (!rst_n)
      (cs_act && !hold_s) |=> (bitcnt == $past(bitcnt));
  endproperty
  a_hold_freeze_r6: assert property (p_hold_freeze_r6);

endmodule

// File: tb/spi_mem_cmd_test.sv
module spi_mem_cmd_test;

  localparam int H = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, cs_n, sck, si, hold_n, so, so_oe;
  logic [8:0] mem_addr;
  logic       mem_we, latch_set, latch_clr, stat_wr;
  logic [7:0] mem_wdata, mem_rdata, stat_wdata, stat_rdata;
  logic       mem_wr_permit, stat_wr_permit;

  spi_mem_cmd uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .latch_set(latch_set),
    .latch_clr(latch_clr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata), .mem_wr_permit(mem_wr_permit),
    .stat_wr_permit(stat_wr_permit)
  );

  logic [7:0] ram [512];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) ram[i] <= 8'h00;
    end else if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
    end
    mem_rdata <= ram[mem_addr];
  end

  int n_set = 0, n_clr = 0, n_sw = 0, n_we = 0;
  logic [7:0] last_sw = 8'h00;
  always @(posedge clk) begin
    if (rst_n) begin
      if (latch_set) n_set <= n_set + 1;
      if (latch_clr) n_clr <= n_clr + 1;
      if (mem_we)    n_we  <= n_we + 1;
      if (stat_wr) begin
        n_sw    <= n_sw + 1;
        last_sw <= stat_wdata;
      end
    end
  end

  int   checks = 0, fails = 0;
  bit   mode3 = 1'b0;
  logic hold_oe;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    sck = mode3;
    step(H);
    cs_n = 1'b0;
    step(H);
  endtask

  task automatic cs_off();
    if (!mode3) sck = 1'b0;
    step(H);
    cs_n = 1'b1;
    sck  = mode3;
    step(2 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      step(H);
      if (i == hold_at) begin
        hold_n = 1'b0;
        step(H);
        hold_oe = so_oe;
        sck = 1'b1; step(H);
        sck = 1'b0; step(H);
        sck = 1'b1; step(H);
        sck = 1'b0; step(H);
        hold_n = 1'b1;
        step(H);
      end
      rx[i] = so;
      sck = 1'b1;
      step(H);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, 8, dummy);
  endtask

  task automatic mem_write(input int start, input int n);
    cs_on();
    send({4'h0, start[8], 3'b010});
    send(start[7:0]);
    for (int k = 0; k < n; k++) send(pat((start + k) % 512));
    cs_off();
  endtask

  task automatic mem_read(input int start, input int n, input string tag);
    logic [7:0] rx;
    cs_on();
    send({4'h0, start[8], 3'b011});
    send(start[7:0]);
    for (int k = 0; k < n; k++) begin
      xfer(~pat(k), 8, rx);
      chk(tag, rx, pat((start + k) % 512));
    end
    cs_off();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int c0;
    logic [7:0] rx;
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    mem_wr_permit = 1'b1; stat_wr_permit = 1'b1; stat_rdata = 8'h0C;
    rst_n = 1'b0;
    step(5);
    chk("R11 so_oe in reset", so_oe, 0);
    chk("R11 strobes in reset", {mem_we, stat_wr, latch_set, latch_clr}, 0);
    rst_n = 1'b1;
    step(5);

    // R1 latch commands
    cs_on(); send(8'h06); cs_off();
    chk("R1 set pulse", n_set, 1);
    cs_on(); send(8'h04); cs_off();
    chk("R1 clr pulse", n_clr, 1);

    // R2 R3 R9 write across the top address, mode 0
    c0 = n_clr;
    mem_write(9'h1F8, 12);
    for (int a = 9'h1F8; a < 512; a++) chk("R2 R3 high write", ram[a], pat(a));
    for (int a = 0; a < 4; a++) chk("R3 wrap write", ram[a], pat(a));
    chk("R3 untouched", ram[4], 0);
    chk("R9 clr after write", n_clr, c0 + 1);

    // R3 R12 full sweep in mode 3
    mode3 = 1'b1;
    mem_write(0, 512);
    for (int a = 0; a < 512; a++) chk("R3 R12 full write", ram[a], pat(a));

    // R4 R12 full read with noise on SI
    mem_read(0, 512, "R4 R12 full read");

    // R4 R2 read wrap, mode 0
    mode3 = 1'b0;
    mem_read(9'h1FD, 5, "R4 R2 wrap read");

    // R10 permit low: no change, address still steps
    cs_on();
    send(8'h02); send(8'h10);
    mem_wr_permit = 1'b0;
    send(8'hAA); send(8'hBB);
    mem_wr_permit = 1'b1;
    send(8'hCC);
    cs_off();
    chk("R10 blocked 0x10", ram[16], pat(16));
    chk("R10 blocked 0x11", ram[17], pat(17));
    chk("R10 step to 0x12", ram[18], 8'hCC);

    // R8 R5 status read
    cs_on();
    send(8'h05);
    chk("R5 oe low after command", so_oe, 0);
    xfer(8'hFF, 8, rx);
    chk("R8 status read", rx, 8'h0C);
    chk("R5 oe high in read", so_oe, 1);
    cs_off();
    chk("R5 oe low when deselected", so_oe, 0);

    // R8 R9 status write
    c0 = n_clr;
    cs_on(); send(8'h01); send(8'h08); cs_off();
    chk("R8 status write count", n_sw, 1);
    chk("R8 status write data", last_sw, 8'h08);
    chk("R9 clr after status write", n_clr, c0 + 1);
    stat_wr_permit = 1'b0;
    cs_on(); send(8'h01); send(8'h04); cs_off();
    stat_wr_permit = 1'b1;
    chk("R8 status write blocked", n_sw, 1);
    chk("R9 clr after blocked write", n_clr, c0 + 2);

    // R7 one command per select
    c0 = n_we;
    cs_on(); send(8'h06); send(8'h02); send(8'h00); send(8'h55); cs_off();
    chk("R7 set once", n_set, 2);
    chk("R7 no write", n_we, c0);
    chk("R7 ram kept", ram[0], pat(0));
    cs_on(); send(8'hFF); send(8'h06); cs_off();
    chk("R7 unknown ignored", n_set, 2);

    // R6 pause during write
    c0 = n_we;
    cs_on(); send(8'h02); send(8'h20); xfer(8'h5A, 3, rx); cs_off();
    chk("R6 paused write data", ram[32], 8'h5A);
    chk("R6 one commit", n_we, c0 + 1);

    // R5 R6 pause during read
    cs_on(); send(8'h03); send(8'h20); xfer(8'h00, 4, rx); cs_off();
    chk("R5 oe low while paused", hold_oe, 0);
    chk("R6 paused read data", rx, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule